// File: doc/BRIEF.md
# Five-Level Pipeline Stage Quantizer

This block is a fixed-point model of one extended 1.5-bit stage of a pipelined converter. It is used to produce realistic stimulus for the digital correction logic that follows. Each accepted sample is a signed 16-bit value in which the reference level equals 4096 counts. The sample is compared with four thresholds. Each threshold is an ideal level plus a signed, programmable offset that models comparator error. From the comparison the block produces a decision code from 0 to 4 and the doubled residue that the next stage would receive.

Samples enter on a valid/ready stream. Each result leaves one cycle later as a {code, residue} pair on a second valid/ready stream. The single output register is the only buffer. It is held unchanged while the consumer stalls, and the input is ready exactly when that register is empty or is being drained in the same cycle. Offset registers are written through plain configuration pins. A write takes effect only while the stage is idle, which means no result is held and no sample is offered. The residue saturates at the 16-bit limits, and a sticky flag records that saturation has happened.

Top module: `five_level_stage`

## Requirements
- R1: The ideal thresholds, indexed 0 to 3 from lowest to highest, are -3072, -1024, +1024 and +3072 counts (that is, -3/4, -1/4, +1/4 and +3/4 of the 4096-count reference). An input exactly equal to an effective threshold counts as at or above it.
- R2: The output code is the number of effective thresholds that are at or below the input. It is always in the range 0 to 4, where 0 is the lowest region and 4 is the highest.
- R3: Before saturation, the residue is 2x+8192 for code 0, 2x+4096 for code 1, 2x for code 2, 2x-4096 for code 3 and 2x-8192 for code 4.
- R4: Each effective threshold equals its ideal value plus a 16-bit signed offset register. The register is selected by `cfg_sel` (0 for the lowest threshold, 3 for the highest) and loaded from `cfg_offset` on a `cfg_we` cycle while the stage is idle. All offsets reset to 0.
- R5: If every offset lies within ±1536 counts (3/8 of the reference) and the input lies within ±5120 counts (5/4 of the reference), then the residue lies within ±5120 counts.
- R6: A residue above 32767 or below -32768 is clamped to that limit. A clamp on any accepted sample sets `sat_sticky`, and only reset clears it.
- R7: A sample accepted on a clock edge (`in_valid` and `in_ready` both high) appears on the output, with `out_valid` high, right after that same edge. This is one cycle of latency.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the code and residue hold their values.
- R9: A `cfg_we` cycle while `out_valid` or `in_valid` is high leaves every offset unchanged.
- R10: After reset, `out_valid` and `sat_sticky` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Stage can take a sample |
| in_sample | input | 16 | Signed input sample, reference level = 4096 |
| out_valid | output | 1 | Result held on the output |
| out_ready | input | 1 | Consumer takes the result |
| out_code | output | 3 | Region code, 0 to 4 |
| out_residue | output | 16 | Signed saturated doubled residue |
| cfg_we | input | 1 | Offset write strobe |
| cfg_sel | input | 2 | Threshold index to write |
| cfg_offset | input | 16 | Signed offset value |
| sat_sticky | output | 1 | Residue has saturated since reset |

## Verification
Code, residue and the sticky flag are all due in the cycle after the accepting edge. The bench therefore drives a sample at a falling edge, lets one rising edge pass, and reads all three outputs at the next falling edge. An offset write is first in force for a sample offered after the write edge. `in_ready` is combinational, so the bench reads it at the falling edge where `out_ready` is changed, before any rising edge. Stall checks repeat the read over several falling edges with `out_ready` low and require identical values each time.

// File: rtl/fls_pkg.sv
package fls_pkg;
  localparam int NUM_THR = 4;
  localparam int IDX_W   = 2;
  localparam int CODE_W  = 3;
  localparam int GUARD   = 3;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/fls_offset_bank.sv
module fls_offset_bank
  import fls_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        idle,
  input  logic                        cfg_we,
  input  logic [IDX_W-1:0]            cfg_sel,
  input  logic [DATA_W-1:0]           cfg_offset,
  output logic [NUM_THR*DATA_W-1:0]   offs_flat
);
  for (genvar k = 0; k < NUM_THR; k++) begin : g_reg
    logic [DATA_W-1:0] off_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        off_q <= '0;
      else if (cfg_we && idle && (cfg_sel == IDX_W'(k)))
        off_q <= cfg_offset;
    end
    assign offs_flat[k*DATA_W +: DATA_W] = off_q;
  end

  // R9: a write while busy must leave the bank untouched
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !idle) |=> $stable(offs_flat));
endmodule

// File: rtl/fls_decide.sv
module fls_decide
  import fls_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int VREF_LOG2 = 12
) (
  input  logic signed [DATA_W-1:0]     sample,
  input  logic [NUM_THR*DATA_W-1:0]    offs_flat,
  output code_t                        code
);
  localparam int EXT_W = DATA_W + GUARD;

  logic signed [EXT_W-1:0] x_ext;
  logic [NUM_THR-1:0]      hit;

  assign x_ext = {{GUARD{sample[DATA_W-1]}}, sample};

  for (genvar k = 0; k < NUM_THR; k++) begin : g_cmp
    localparam int IDEAL_I = ((2 * k - 3) * (1 << VREF_LOG2)) / 4;
    localparam logic signed [EXT_W-1:0] IDEAL = EXT_W'(IDEAL_I);
    logic [DATA_W-1:0]       off_raw;
    logic signed [EXT_W-1:0] eff;
    assign off_raw = offs_flat[k*DATA_W +: DATA_W];
    assign eff     = IDEAL + {{GUARD{off_raw[DATA_W-1]}}, off_raw};
    assign hit[k]  = (x_ext >= eff);
  end

  always_comb begin
    code = '0;
    for (int k = 0; k < NUM_THR; k++)
      code = code + code_t'(hit[k]);
  end
endmodule

// File: rtl/fls_residue.sv
module fls_residue
  import fls_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int VREF_LOG2 = 12
) (
  input  logic signed [DATA_W-1:0] sample,
  input  code_t                    code,
  output logic signed [DATA_W-1:0] residue,
  output logic                     sat
);
  localparam int EXT_W = DATA_W + GUARD;
  localparam logic signed [EXT_W-1:0] VREF1 = EXT_W'(1 << VREF_LOG2);
  localparam logic signed [EXT_W-1:0] VREF2 = EXT_W'(2 << VREF_LOG2);
  localparam logic signed [EXT_W-1:0] MAXV  = EXT_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] MINV  = -MAXV - EXT_W'(1);

  logic signed [EXT_W-1:0] x2;
  logic signed [EXT_W-1:0] step;
  logic signed [EXT_W-1:0] wide;

  assign x2 = {{(GUARD-1){sample[DATA_W-1]}}, sample, 1'b0};

  always_comb begin
    case (code)
      3'd0:    step = VREF2;
      3'd1:    step = VREF1;
      3'd3:    step = -VREF1;
      3'd4:    step = -VREF2;
      default: step = '0;
    endcase
  end

  assign wide = x2 + step;

  always_comb begin
    sat = 1'b0;
    residue = wide[DATA_W-1:0];
    if (wide > MAXV) begin
      sat = 1'b1;
      residue = MAXV[DATA_W-1:0];
    end else if (wide < MINV) begin
      sat = 1'b1;
      residue = MINV[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/five_level_stage.sv
module five_level_stage
  import fls_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int VREF_LOG2 = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    in_sample,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CODE_W-1:0]    out_code,
  output logic [DATA_W-1:0]    out_residue,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_sel,
  input  logic [DATA_W-1:0]    cfg_offset,
  output logic                 sat_sticky
);
  localparam int IN_LIM  = (5 * (1 << VREF_LOG2)) / 4;
  localparam int OFF_LIM = (3 * (1 << VREF_LOG2)) / 8;

  logic                      accept;
  logic                      idle;
  logic [NUM_THR*DATA_W-1:0] offs_flat;
  code_t                     code_w;
  logic signed [DATA_W-1:0]  res_w;
  logic                      sat_w;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign idle     = !out_valid && !in_valid;

  fls_offset_bank #(.DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .idle(idle), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_offset(cfg_offset), .offs_flat(offs_flat)
  );

  fls_decide #(.DATA_W(DATA_W), .VREF_LOG2(VREF_LOG2)) u_decide (
    .sample(in_sample), .offs_flat(offs_flat), .code(code_w)
  );

  fls_residue #(.DATA_W(DATA_W), .VREF_LOG2(VREF_LOG2)) u_res (
    .sample(in_sample), .code(code_w), .residue(res_w), .sat(sat_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_code    <= '0;
      out_residue <= '0;
      sat_sticky  <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_code    <= code_w;
      out_residue <= res_w;
      if (sat_w) sat_stick_set();
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  task automatic sat_stick_set();
    sat_sticky <= 1'b1;
  endtask

  // Bound check inputs: sample and all offsets inside their tolerance windows
  logic in_bounds;
  always_comb begin
    in_bounds = ($signed(in_sample) <= IN_LIM) && ($signed(in_sample) >= -IN_LIM);
    for (int k = 0; k < NUM_THR; k++) begin
      if (($signed(offs_flat[k*DATA_W +: DATA_W]) > OFF_LIM) ||
          ($signed(offs_flat[k*DATA_W +: DATA_W]) < -OFF_LIM))
        in_bounds = 1'b0;
    end
  end

  assert_residue_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_bounds) |=> (($signed(out_residue) <= IN_LIM) && ($signed(out_residue) >= -IN_LIM)));

  assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_code <= 3'd4));

  assert_one_cycle_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_hold_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_residue)));

  assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_sticky_never_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sat_sticky));
endmodule

// File: tb/five_level_stage_tb_top.sv
`timescale 1ns/1ps
module five_level_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_sample = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_code;
  logic [15:0] out_residue;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_offset = '0;
  logic        sat_sticky;

  int n_checks = 0;
  int n_fail = 0;
  int boff [4] = '{0, 0, 0, 0};

  always #4 clk = ~clk;

  five_level_stage dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_residue(out_residue), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_offset(cfg_offset), .sat_sticky(sat_sticky)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int x);
    int c = 0;
    for (int k = 0; k < 4; k++)
      if (x >= ((2 * k - 3) * 1024 + boff[k])) c++;
    return c;
  endfunction

  function automatic int exp_res(input int x);
    int r = 2 * x + (2 - exp_code(x)) * 4096;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int s16(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  // Drive one sample, sample the result one cycle after acceptance (R7)
  task automatic push(input int x, input string req);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_sample = 16'(x);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R7", int'(out_valid), 1);
    check(int'(out_code) == exp_code(x), req, int'(out_code), exp_code(x));
    check(s16(out_residue) == exp_res(x), req, s16(out_residue), exp_res(x));
  endtask

  task automatic write_off(input int sel, input int val);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_offset = 16'(val);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    boff[sel] = val;
  endtask

  task automatic t_reset();
    check(out_valid === 1'b0, "R10 out_valid", int'(out_valid), 0);
    check(sat_sticky === 1'b0, "R10 sticky", int'(sat_sticky), 0);
    check(in_ready === 1'b1, "R10 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_ideal_regions();
    push(0, "R2 mid");
    push(1024, "R1 equal upper-inner");
    push(1023, "R1 below upper-inner");
    push(-1024, "R1 equal lower-inner");
    push(-1025, "R1 below lower-inner");
    push(3072, "R1 equal upper-outer");
    push(-3072, "R1 equal lower-outer");
    push(-3073, "R3 code0");
    push(5000, "R3 code4");
    push(-5120, "R3 low edge");
    push(5120, "R3 high edge");
  endtask

  task automatic t_offsets();
    int worst = 0;
    write_off(0, -1536); write_off(1, -1536);
    write_off(2, 1536);  write_off(3, 1536);
    push(2559, "R4 below shifted");
    push(2560, "R4 at shifted");
    push(-2561, "R4 below shifted low");
    for (int x = -5120; x <= 5120; x += 40) begin
      push(x, "R4 sweep");
      if (s16(out_residue) > worst) worst = s16(out_residue);
      if (-s16(out_residue) > worst) worst = -s16(out_residue);
    end
    check(worst <= 5120, "R5 wide offsets", worst, 5120);
    write_off(0, 1536);  write_off(1, 1536);
    write_off(2, -1536); write_off(3, -1536);
    worst = 0;
    for (int x = -5120; x <= 5120; x += 40) begin
      push(x, "R4 sweep inv");
      if (s16(out_residue) > worst) worst = s16(out_residue);
      if (-s16(out_residue) > worst) worst = -s16(out_residue);
    end
    check(worst <= 5120, "R5 narrow offsets", worst, 5120);
    for (int k = 0; k < 4; k++) write_off(k, 0);
  endtask

  task automatic t_backpressure();
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_sample = 16'(-2000);
    @(posedge clk);
    @(negedge clk);
    in_sample = 16'(3500);
    check(in_ready === 1'b0, "R8 ready low when full", int'(in_ready), 0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(out_valid === 1'b1 && int'(out_code) == 1, "R8 hold code", int'(out_code), 1);
      check(s16(out_residue) == exp_res(-2000), "R8 hold res", s16(out_residue), exp_res(-2000));
    end
    out_ready = 1'b1;
    #1;
    check(in_ready === 1'b1, "R8 ready with out_ready", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(int'(out_code) == 4, "R8 next code", int'(out_code), 4);
    check(s16(out_residue) == -1192, "R8 next res", s16(out_residue), -1192);
  endtask

  task automatic t_cfg_busy();
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_sample = 16'(1000);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_offset = 16'(-500);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    check(int'(out_code) == 2, "R8 held during write", int'(out_code), 2);
    out_ready = 1'b1;
    push(1000, "R9 busy write ignored");
  endtask

  task automatic t_saturation();
    check(sat_sticky === 1'b0, "R6 sticky before", int'(sat_sticky), 0);
    push(30000, "R6 clamp high");
    check(sat_sticky === 1'b1, "R6 sticky set", int'(sat_sticky), 1);
    push(-30000, "R6 clamp low");
    push(100, "R6 normal after");
    check(sat_sticky === 1'b1, "R6 sticky holds", int'(sat_sticky), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ideal_regions();
    t_offsets();
    t_backpressure();
    t_cfg_busy();
    t_saturation();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule